// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM refreshed while a separate command path performs normal reads and writes. A down-counter reloads from a programmable rate value and marks a refresh as due each time it expires. Due refreshes that have not yet been issued are held in a saturating debt counter. The block issues an auto-refresh command when the command path has nothing to do. When the debt reaches its ceiling, refresh takes precedence over a waiting access.

The block also places the memory into self-refresh and brings it back out. Software sets a control bit to ask for self-refresh. The sequencer first lets any access in flight finish and pays off the whole refresh debt. It then issues the self-refresh command and drops the clock enable in the same cycle. The device wakes when the control bit is cleared, or when the command path asks for an access while the bit is still set. On wake, the clock enable rises first. The next cycle carries one auto-refresh, and only after that can an access be granted.

Two registers program the block through a byte-enabled write port. A write to the lower bytes of the configuration register pulses an initialization-start output. A write to the top byte alone changes only the self-refresh bit.

Top module: `sdr_refresh_seq`

## Requirements
- R1: During and after reset, with no traffic: `cke` is 1, neither command output is asserted, `refreshDebt` is 0, `srActive` is 0 and `initStart` is 0. The rate value resets to `RATE_RESET` (782).
- R2: While the command path is idle, `cmdRefresh` pulses exactly once every N clocks. N is the rate value, for example 782 at reset or 20 after a write to the rate register (`regSel`=1, value in the low `RATE_W` bits, byte lanes enabled by `regBe`).
- R3: While `accBusy` is high, no auto-refresh is issued. `refreshDebt` counts expiries and saturates at `DEBT_MAX` (8).
- R4: While `refreshDebt` is below `DEBT_MAX`, a pending `accReq` (with `accBusy` low) is granted and no refresh is issued. The debt is paid off once the request goes away.
- R5: While `refreshDebt` equals `DEBT_MAX` and `accBusy` is low, `cmdRefresh` is issued and `accGrant` is held low.
- R6: Setting the self-refresh bit while `accBusy` is high issues no `cmdSelfRefresh`, and `cke` stays 1.
- R7: Before `cmdSelfRefresh`, at least as many auto-refreshes are issued as the debt held when the access finished. `refreshDebt` is 0 in the `cmdSelfRefresh` cycle.
- R8: `cke` falls in the same cycle as the one-cycle `cmdSelfRefresh` pulse. While in self-refresh, `cke` stays 0 and `srActive` stays 1.
- R9: During self-refresh the interval counter is frozen: no `cmdRefresh` occurs and `refreshDebt` stays 0, however long the state lasts.
- R10: After the self-refresh bit is cleared, `cke` rises one cycle later. The following cycle carries one `cmdRefresh`.
- R11: An `accReq` during self-refresh wakes the device even with the bit still set. The wake takes a `cke`-high cycle and an exit-refresh cycle, both with `accGrant` low. The request is granted in the next cycle. Once the command path is idle again, self-refresh is re-entered.
- R12: The configuration register has `regSel`=0 and the self-refresh bit at bit 31. A write that enables only lane 3 (`regBe`=4'b1000) changes the bit without pulsing `initStart`. A write enabling any of lanes 0 to 2 pulses `initStart` for one cycle.
- R13: The first periodic `cmdRefresh` after the exit refresh arrives N+1 clocks after it, because the counter restarts from the rate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = configuration register, 1 = rate register |
| regBe | input | 4 | Byte-lane enables for the write |
| regWdata | input | 32 | Write data |
| accReq | input | 1 | Command path requests an SDRAM access |
| accBusy | input | 1 | A granted access is still in flight |
| accGrant | output | 1 | Access may start this cycle |
| cmdRefresh | output | 1 | Issue auto-refresh this cycle |
| cmdSelfRefresh | output | 1 | Issue self-refresh entry this cycle |
| cke | output | 1 | SDRAM clock enable |
| initStart | output | 1 | One-cycle request to run device initialization |
| srActive | output | 1 | Device is held in self-refresh |
| refreshDebt | output | $clog2(DEBT_MAX+1) | Refreshes due but not yet issued |

## Verification
The bench measures the gap between refresh pulses at two rate values. A counter off by one shows up directly as a period of N-1 or N+1. The bench fills the debt to its ceiling behind a busy access and then holds a request. Every cycle it checks that the grant and the refresh swap correctly around the ceiling, so a design that starves refresh or grants at full debt is caught. It enters self-refresh with debt outstanding and an access in flight, to catch a design that sleeps too early or with refreshes owed. It leaves self-refresh both by clearing the bit and by an access request. A wrong wake order, an early grant or a missing counter restart shows up as a misplaced `cke` edge, grant or first periodic refresh. Top-byte and low-byte configuration writes separate a correct `initStart` from one that fires on every write.

// File: rtl/sdr_refresh_pkg.sv
`timescale 1ns/1ps
package sdr_refresh_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_HOLD,
    ST_WAKE,
    ST_EXITREF
  } seqState_t;

  // strobes from the control FSM to the timer/debt datapath
  typedef struct packed {
    logic issueRefresh;
    logic holdTimer;
    logic reloadTimer;
  } seqStrobe_t;

endpackage

// File: rtl/sdr_refresh_regs.sv
`timescale 1ns/1ps
module sdr_refresh_regs #(
  parameter int RATE_W     = 16,
  parameter int RATE_RESET = 782
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [3:0]        wrBe,
  input  logic [31:0]       wrData,
  output logic [RATE_W-1:0] rate,
  output logic [RATE_W-1:0] rateNext,
  output logic              rateLoad,
  output logic              srBit,
  output logic              initStart
);

  localparam int RATE_BYTES = (RATE_W + 7) / 8;

  logic rateWr;
  logic cfgWr;
  logic unusedData;

  assign rateWr     = wrEn && wrSel;
  assign cfgWr      = wrEn && !wrSel;
  assign rateLoad   = rateWr && (|wrBe[RATE_BYTES-1:0]);
  assign unusedData = ^wrData;

  // per-bit lane merge of the rate value
  for (genvar i = 0; i < RATE_W; i++) begin : g_rateBit
    assign rateNext[i] = (rateWr && wrBe[i/8]) ? wrData[i] : rate[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rate      <= RATE_W'(RATE_RESET);
      srBit     <= 1'b0;
      initStart <= 1'b0;
    end else begin
      rate      <= rateNext;
      if (cfgWr && wrBe[3]) srBit <= wrData[31];
      initStart <= cfgWr && (|wrBe[2:0]);
    end
  end

endmodule

// File: rtl/sdr_refresh_timer.sv
`timescale 1ns/1ps
module sdr_refresh_timer
  import sdr_refresh_pkg::*;
#(
  parameter int RATE_W     = 16,
  parameter int RATE_RESET = 782,
  parameter int DEBT_MAX   = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [RATE_W-1:0]                rate,
  input  logic [RATE_W-1:0]                rateNext,
  input  logic                             rateLoad,
  input  seqStrobe_t                       strobe,
  output logic                             tick,
  output logic [$clog2(DEBT_MAX+1)-1:0]    debt,
  output logic                             debtZero,
  output logic                             debtFull
);

  localparam int DEBT_W = $clog2(DEBT_MAX + 1);

  logic [RATE_W-1:0] intervalCnt;
  logic              frozen;
  logic              debtInc;
  logic              debtDec;

  assign frozen   = strobe.holdTimer || strobe.reloadTimer || rateLoad;
  assign tick     = !frozen && (intervalCnt <= RATE_W'(1));
  assign debtZero = (debt == '0);
  assign debtFull = (debt == DEBT_W'(DEBT_MAX));
  assign debtInc  = tick && !debtFull;
  assign debtDec  = strobe.issueRefresh && !debtZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt <= RATE_W'(RATE_RESET);
    end else if (rateLoad) begin
      intervalCnt <= rateNext;
    end else if (strobe.reloadTimer) begin
      intervalCnt <= rate;
    end else if (!strobe.holdTimer) begin
      intervalCnt <= tick ? rate : intervalCnt - RATE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      debt <= '0;
    end else begin
      case ({debtInc, debtDec})
        2'b10:   debt <= debt + DEBT_W'(1);
        2'b01:   debt <= debt - DEBT_W'(1);
        default: debt <= debt;
      endcase
    end
  end

endmodule

// File: rtl/sdr_refresh_ctrl.sv
`timescale 1ns/1ps
module sdr_refresh_ctrl
  import sdr_refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       srBit,
  input  logic       accReq,
  input  logic       accBusy,
  input  logic       tick,
  input  logic       debtZero,
  input  logic       debtFull,
  output seqStrobe_t strobe,
  output logic       accGrant,
  output logic       cmdRefresh,
  output logic       cmdSelfRefresh,
  output logic       cke,
  output logic       srActive
);

  seqState_t state;
  seqState_t stateNext;
  logic      refreshGo;
  logic      enterSr;

  assign refreshGo = !debtZero && !accBusy && (debtFull || !accReq);
  assign enterSr   = srBit && debtZero && !tick && !accReq && !accBusy;

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    accGrant       = 1'b0;
    cmdRefresh     = 1'b0;
    cmdSelfRefresh = 1'b0;
    cke            = 1'b1;
    srActive       = 1'b0;
    case (state)
      ST_RUN: begin
        cmdRefresh          = refreshGo;
        strobe.issueRefresh = refreshGo;
        accGrant            = accReq && !accBusy && !debtFull;
        if (enterSr) stateNext = ST_ENTER;
      end
      ST_ENTER: begin
        cmdSelfRefresh   = 1'b1;
        cke              = 1'b0;
        srActive         = 1'b1;
        strobe.holdTimer = 1'b1;
        stateNext        = ST_HOLD;
      end
      ST_HOLD: begin
        cke              = 1'b0;
        srActive         = 1'b1;
        strobe.holdTimer = 1'b1;
        if (!srBit || accReq) stateNext = ST_WAKE;
      end
      ST_WAKE: begin
        strobe.holdTimer = 1'b1;
        stateNext        = ST_EXITREF;
      end
      ST_EXITREF: begin
        cmdRefresh         = 1'b1;
        strobe.reloadTimer = 1'b1;
        stateNext          = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/sdr_refresh_seq.sv
`timescale 1ns/1ps
module sdr_refresh_seq
  import sdr_refresh_pkg::*;
#(
  parameter int RATE_W     = 16,
  parameter int RATE_RESET = 782,
  parameter int DEBT_MAX   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic                          regSel,
  input  logic [3:0]                    regBe,
  input  logic [31:0]                   regWdata,
  input  logic                          accReq,
  input  logic                          accBusy,
  output logic                          accGrant,
  output logic                          cmdRefresh,
  output logic                          cmdSelfRefresh,
  output logic                          cke,
  output logic                          initStart,
  output logic                          srActive,
  output logic [$clog2(DEBT_MAX+1)-1:0] refreshDebt
);

  logic [RATE_W-1:0] rate;
  logic [RATE_W-1:0] rateNext;
  logic              rateLoad;
  logic              srBit;
  logic              tick;
  logic              debtZero;
  logic              debtFull;
  seqStrobe_t        strobe;

  sdr_refresh_regs #(.RATE_W(RATE_W), .RATE_RESET(RATE_RESET)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrSel(regSel), .wrBe(regBe),
    .wrData(regWdata), .rate(rate), .rateNext(rateNext), .rateLoad(rateLoad),
    .srBit(srBit), .initStart(initStart)
  );

  sdr_refresh_timer #(.RATE_W(RATE_W), .RATE_RESET(RATE_RESET), .DEBT_MAX(DEBT_MAX)) u_timer (
    .clk(clk), .rstN(rstN), .rate(rate), .rateNext(rateNext), .rateLoad(rateLoad),
    .strobe(strobe), .tick(tick), .debt(refreshDebt), .debtZero(debtZero),
    .debtFull(debtFull)
  );

  sdr_refresh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .srBit(srBit), .accReq(accReq), .accBusy(accBusy),
    .tick(tick), .debtZero(debtZero), .debtFull(debtFull), .strobe(strobe),
    .accGrant(accGrant), .cmdRefresh(cmdRefresh), .cmdSelfRefresh(cmdSelfRefresh),
    .cke(cke), .srActive(srActive)
  );

endmodule

// File: rtl/sdr_refresh_seq_chk.sv
`timescale 1ns/1ps
module sdr_refresh_seq_chk #(
  parameter int DEBT_MAX = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWrEn,
  input logic                          regSel,
  input logic [3:0]                    regBe,
  input logic                          accReq,
  input logic                          accBusy,
  input logic                          accGrant,
  input logic                          cmdRefresh,
  input logic                          cmdSelfRefresh,
  input logic                          cke,
  input logic                          initStart,
  input logic                          srActive,
  input logic [$clog2(DEBT_MAX+1)-1:0] refreshDebt
);

  localparam int DEBT_W = $clog2(DEBT_MAX + 1);

  p_debt_ceiling_r3: assert property (@(posedge clk) disable iff (!rstN)
    refreshDebt <= DEBT_W'(DEBT_MAX));

  p_refresh_beats_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdRefresh |-> !accGrant);

  p_busy_blocks_sleep_r6: assert property (@(posedge clk) disable iff (!rstN)
    accBusy |-> !cmdSelfRefresh);

  p_debt_paid_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdSelfRefresh |-> (refreshDebt == '0));

  p_cke_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdSelfRefresh |-> !cke);

  p_cke_stays_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdSelfRefresh |=> !cke);

  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (srActive && !cmdSelfRefresh) |-> (!cmdRefresh && $stable(refreshDebt)));

  p_wake_refresh_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |=> (cmdRefresh && !accGrant));

  p_wake_no_grant_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> !accGrant);

  p_top_byte_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && (regBe[2:0] == 3'b000)) |=> !initStart);

  p_low_byte_init_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && (regBe[2:0] != 3'b000)) |=> initStart);

  p_one_command: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdRefresh && cmdSelfRefresh));

  p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> (accReq && !accBusy));

endmodule

bind sdr_refresh_seq sdr_refresh_seq_chk #(.DEBT_MAX(DEBT_MAX)) u_chk (.*);

// File: tb/tb_sdr_refresh_seq.sv
`timescale 1ns/1ps
module tb_sdr_refresh_seq;

  localparam int DEBT_MAX = 8;
  localparam int DEBT_W   = $clog2(DEBT_MAX + 1);
  localparam int FAST     = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regSel = 1'b0;
  logic [3:0]        regBe = 4'b0;
  logic [31:0]       regWdata = 32'b0;
  logic              accReq = 1'b0;
  logic              accBusy = 1'b0;
  logic              accGrant;
  logic              cmdRefresh;
  logic              cmdSelfRefresh;
  logic              cke;
  logic              initStart;
  logic              srActive;
  logic [DEBT_W-1:0] refreshDebt;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sdr_refresh_seq #(.RATE_W(16), .RATE_RESET(782), .DEBT_MAX(DEBT_MAX)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regBe(regBe),
    .regWdata(regWdata), .accReq(accReq), .accBusy(accBusy), .accGrant(accGrant),
    .cmdRefresh(cmdRefresh), .cmdSelfRefresh(cmdSelfRefresh), .cke(cke),
    .initStart(initStart), .srActive(srActive), .refreshDebt(refreshDebt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic settle();
    #0.2;
  endtask

  task automatic regWrite(input bit sel, input logic [3:0] be, input logic [31:0] d);
    step();
    regWrEn = 1'b1; regSel = sel; regBe = be; regWdata = d;
    step();
    regWrEn = 1'b0; regBe = 4'b0;
    settle();
  endtask

  task automatic waitRefresh(input int limit, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!cmdRefresh && n < limit);
  endtask

  task automatic waitSleep(input int limit);
    int n = 0;
    while (!cmdSelfRefresh && n < limit) begin
      step();
      n++;
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) step();
    settle();
    chk(cke === 1'b1, "R1 cke", int'(cke), 1);
    chk(!cmdRefresh && !cmdSelfRefresh, "R1 commands", int'(cmdRefresh), 0);
    chk(refreshDebt == 0, "R1 debt", int'(refreshDebt), 0);
    chk(!srActive && !initStart && !accGrant, "R1 status", int'(srActive), 0);
    step();
    rstN = 1'b1;
  endtask

  task automatic t_period_default();
    int n;
    waitRefresh(2000, n);
    chk(cmdRefresh, "R2 first refresh after reset", int'(cmdRefresh), 1);
    for (int k = 0; k < 2; k++) begin
      waitRefresh(2000, n);
      chk(n == 782, "R2 default interval", n, 782);
    end
  endtask

  task automatic t_period_fast();
    int n;
    regWrite(1'b1, 4'b0011, 32'(FAST));
    waitRefresh(100, n);
    for (int k = 0; k < 2; k++) begin
      waitRefresh(100, n);
      chk(n == FAST, "R2 programmed interval", n, FAST);
    end
  endtask

  task automatic t_backlog();
    int pulses = 0;
    step();
    accBusy = 1'b1;
    for (int k = 0; k < 12 * FAST; k++) begin
      step();
      if (cmdRefresh) pulses++;
    end
    chk(pulses == 0, "R3 no refresh while busy", pulses, 0);
    chk(refreshDebt == DEBT_W'(DEBT_MAX), "R3 debt saturates", int'(refreshDebt), DEBT_MAX);
  endtask

  task automatic t_priority();
    int n = 0;
    step();
    accBusy = 1'b0;
    accReq  = 1'b1;
    settle();
    chk(cmdRefresh && !accGrant, "R5 full debt refresh wins", int'(accGrant), 0);
    step();
    chk(!cmdRefresh && accGrant, "R4 grant below ceiling", int'(accGrant), 1);
    chk(refreshDebt == DEBT_W'(DEBT_MAX - 1), "R4 debt after one refresh",
        int'(refreshDebt), DEBT_MAX - 1);
    for (int k = 0; k < 30; k++) begin
      step();
      if (refreshDebt < DEBT_W'(DEBT_MAX))
        chk(!cmdRefresh && accGrant, "R4 request served first", int'(cmdRefresh), 0);
      else
        chk(cmdRefresh && !accGrant, "R5 ceiling refresh", int'(accGrant), 0);
    end
    step();
    accReq = 1'b0;
    while (refreshDebt != 0 && n < 20) begin
      step();
      n++;
    end
    chk(refreshDebt == 0, "R4 debt paid when idle", int'(refreshDebt), 0);
  endtask

  task automatic t_sleep_entry();
    int d0;
    int refs = 0;
    int n = 0;
    step();
    accBusy = 1'b1;
    repeat (70) step();
    regWrite(1'b0, 4'b1000, 32'h8000_0000);
    chk(!initStart, "R12 top byte write no init", int'(initStart), 0);
    for (int k = 0; k < 10; k++) begin
      step();
      chk(!cmdSelfRefresh && cke, "R6 wait for access", int'(cmdSelfRefresh), 0);
    end
    d0 = int'(refreshDebt);
    chk(d0 > 0, "R7 debt outstanding", d0, 1);
    step();
    accBusy = 1'b0;
    settle();
    while (!cmdSelfRefresh && n < 60) begin
      if (cmdRefresh) refs++;
      step();
      n++;
    end
    chk(cmdSelfRefresh, "R8 sleep reached", int'(cmdSelfRefresh), 1);
    chk(refs >= d0, "R7 debt flushed first", refs, d0);
    chk(refreshDebt == 0, "R7 zero debt at sleep", int'(refreshDebt), 0);
    chk(!cke && srActive, "R8 cke low with sleep command", int'(cke), 0);
  endtask

  task automatic t_sleep_hold();
    int bad = 0;
    for (int k = 0; k < 3 * FAST; k++) begin
      step();
      if (cke || !srActive || cmdRefresh || refreshDebt != 0) bad++;
    end
    chk(bad == 0, "R9 frozen in sleep (R8 cke low)", bad, 0);
  endtask

  task automatic t_exit_clear();
    int n;
    regWrite(1'b0, 4'b1000, 32'h0);
    chk(!initStart, "R12 top byte clear no init", int'(initStart), 0);
    chk(!cke, "R10 cke low before wake", int'(cke), 0);
    step();
    chk(cke && !cmdRefresh && !srActive, "R10 cke rises", int'(cke), 1);
    step();
    chk(cmdRefresh && cke, "R10 exit refresh", int'(cmdRefresh), 1);
    waitRefresh(100, n);
    chk(n == FAST + 1, "R13 counter restarts", n, FAST + 1);
  endtask

  task automatic t_exit_access();
    regWrite(1'b0, 4'b1000, 32'h8000_0000);
    waitSleep(60);
    chk(cmdSelfRefresh, "R11 sleep entered", int'(cmdSelfRefresh), 1);
    repeat (5) step();
    accReq = 1'b1;
    settle();
    chk(!accGrant && !cke, "R11 asleep on request", int'(accGrant), 0);
    step();
    chk(cke && !accGrant && !cmdRefresh, "R11 wake cycle", int'(accGrant), 0);
    step();
    chk(cmdRefresh && !accGrant, "R11 exit refresh before grant", int'(accGrant), 0);
    step();
    chk(accGrant && cke, "R11 request granted", int'(accGrant), 1);
    step();
    accReq  = 1'b0;
    accBusy = 1'b1;
    repeat (3) step();
    chk(!srActive && cke, "R11 awake while busy", int'(srActive), 0);
    step();
    accBusy = 1'b0;
    waitSleep(60);
    chk(cmdSelfRefresh, "R11 sleep re-entered", int'(cmdSelfRefresh), 1);
    regWrite(1'b0, 4'b1000, 32'h0);
    repeat (4) step();
    chk(cke && !srActive, "R10 awake after clear", int'(cke), 1);
  endtask

  task automatic t_init();
    int bad = 0;
    regWrite(1'b0, 4'b0001, 32'h0);
    chk(initStart, "R12 low byte write pulses init", int'(initStart), 1);
    step();
    chk(!initStart, "R12 init single cycle", int'(initStart), 0);
    for (int k = 0; k < 5; k++) begin
      step();
      if (srActive || cmdSelfRefresh) bad++;
    end
    chk(bad == 0, "R12 low byte leaves sleep bit", bad, 0);
  endtask

  initial begin
    t_reset();
    t_period_default();
    t_period_fast();
    t_backlog();
    t_priority();
    t_sleep_entry();
    t_sleep_hold();
    t_exit_clear();
    t_exit_access();
    t_init();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule